// File: doc/BRIEF.md
# Configurable Synchronous Serial Port

This block is a shift-register serial port. It exchanges one word with a peer in each transfer over three lines: a serial clock, a data input and a data output. The word is sent and received at the same time. The role is chosen at run time. As master, the port makes the serial clock itself from the system clock, divided by a 4-bit setting. As slave, it follows an external serial clock, which it synchronises and edge-detects in the system clock domain. The bit order (LSB or MSB first) and the word length (8 or 16 bits) are also chosen at run time.

Software writes the mode register while the port is idle. It then pulses `start` with the transmit word on `tx_word`. When the one-cycle `done` pulse appears, which acts as the completion interrupt, software reads the received word from `rx_word`. The serial clock idles high. Output data changes on the falling edge and input data is sampled on the rising edge.

Top module: `sio_port`

## Requirements
- R1: After reset, `busy` = 0, `done` = 0, `sck_out` = 1 and `rx_word` = 0.
- R2: In master mode, with the clock-select field at value D, each high and each low half of `sck_out` lasts D+1 system clocks, giving 50% duty. The first falling edge shows on `sck_out` D+1 clocks after the clock edge that accepts `start`.
- R3: With MSB-first order (`cfg_lsb_first` = 0) and 16-bit length (`cfg_wide` = 1), `tx_word[15]` is sent first and `tx_word[0]` last. The first bit received lands in `rx_word[15]`.
- R4: With LSB-first order (`cfg_lsb_first` = 1), bit 0 of the word is sent first. The first bit received lands in `rx_word[0]`.
- R5: With 8-bit length (`cfg_wide` = 0), a transfer has exactly 8 serial clock cycles and sends only `tx_word[7:0]`. The received byte appears in `rx_word[7:0]`, with `rx_word[15:8]` = 0. A 16-bit transfer has exactly 16 cycles.
- R6: In slave mode (`cfg_master` = 0), bits move on the edges of `sck_in`, which passes through a two-flop synchroniser, and `sck_out` stays at 1 for the whole time.
- R7: `sout` changes only at a falling edge of the serial clock, and input data is sampled at a rising edge. `sout` is therefore stable across every rising edge.
- R8: `busy` rises on the clock edge that accepts `start`. It falls on the clock edge of the last rising serial-clock edge. On that same edge `done` pulses for exactly one cycle and `rx_word` takes the received word.
- R9: While `busy` is 1, a write to the mode register (`cfg_we`) and a new `start` are both ignored. The running transfer and the next transfer keep the old mode and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_master | input | 1 | 1 = master (internal clock), 0 = slave |
| cfg_lsb_first | input | 1 | 1 = LSB first, 0 = MSB first |
| cfg_wide | input | 1 | 1 = 16-bit word, 0 = 8-bit word |
| cfg_div | input | 4 | Master clock select: half period = value + 1 clocks |
| start | input | 1 | Start pulse; latches `tx_word` when idle |
| tx_word | input | 16 | Word to transmit |
| sck_in | input | 1 | External serial clock (slave mode) |
| sin | input | 1 | Serial data input |
| sck_out | output | 1 | Serial clock output (master mode, idles high) |
| sout | output | 1 | Serial data output |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse (interrupt) |
| rx_word | output | 16 | Last received word |

## Verification
As master, the port exchanges words with a bench peer in all four combinations of bit order and word length, each at a different clock-select value. These runs separate a reversed order from a correct one, check that the upper byte is ignored in 8-bit mode, and measure the half period and the delay to the first edge. Slave runs with an external clock cover both orders and check that the synchroniser path moves bits while `sck_out` stays high. In one transfer a mode write and a second start are issued mid-word with values that differ in every field. The transfer without a mode write that follows shows whether either one was wrongly taken.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int LONG_W  = 16;
  localparam int SHORT_W = 8;
  localparam int DIV_W   = 4;
  localparam int BCNT_W  = $clog2(LONG_W + 1);

  typedef struct packed {
    logic             master;
    logic             lsb_first;
    logic             wide;
    logic [DIV_W-1:0] div;
  } sio_mode_t;

  function automatic logic [LONG_W-1:0] rev_word(input logic [LONG_W-1:0] w);
    logic [LONG_W-1:0] r;
    for (int i = 0; i < LONG_W; i++) r[i] = w[LONG_W-1-i];
    return r;
  endfunction

  // Shift register image: the bit sent first sits in the top position
  function automatic logic [LONG_W-1:0] pack_tx(input logic [LONG_W-1:0] w,
                                                input sio_mode_t m);
    if (m.lsb_first) return rev_word(w);
    if (m.wide)      return w;
    return {w[SHORT_W-1:0], {(LONG_W-SHORT_W){1'b0}}};
  endfunction

  // Received image: first bit received is at position (length-1)
  function automatic logic [LONG_W-1:0] unpack_rx(input logic [LONG_W-1:0] r,
                                                  input sio_mode_t m);
    logic [LONG_W-1:0] rv;
    rv = rev_word(r);
    if (m.wide)      return m.lsb_first ? rv : r;
    if (m.lsb_first) return {{(LONG_W-SHORT_W){1'b0}}, rv[LONG_W-1 -: SHORT_W]};
    return {{(LONG_W-SHORT_W){1'b0}}, r[SHORT_W-1:0]};
  endfunction

  function automatic logic [BCNT_W-1:0] last_index(input sio_mode_t m);
    return m.wide ? BCNT_W'(LONG_W - 1) : BCNT_W'(SHORT_W - 1);
  endfunction
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RESET_VAL;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen
  import sio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [DIV_W-1:0] cnt;
  logic             half_end;

  assign half_end = run && (cnt == div);
  assign fall_ev  = half_end && sck;
  assign rise_ev  = half_end && !sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (half_end) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= div)); // R2
  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_ev && fall_ev)); // R2
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LONG_W-1:0] tx_word,
  input  sio_mode_t         mode,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              sin_bit,
  output logic              sout,
  output logic              busy,
  output logic              done,
  output logic [LONG_W-1:0] rx_word
);
  logic [LONG_W-1:0] txsr;
  logic [LONG_W-1:0] rxsr;
  logic [LONG_W-1:0] rx_next;
  logic [BCNT_W-1:0] bit_cnt;
  logic              start_accept;
  logic              last_bit;

  assign start_accept = start && !busy;
  assign last_bit     = (bit_cnt == last_index(mode));
  assign rx_next      = {rxsr[LONG_W-2:0], sin_bit};
  assign sout         = txsr[LONG_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsr    <= '0;
      rxsr    <= '0;
      bit_cnt <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rx_word <= '0;
    end else begin
      done <= 1'b0;
      if (start_accept) begin
        txsr    <= pack_tx(tx_word, mode);
        rxsr    <= '0;
        bit_cnt <= '0;
        busy    <= 1'b1;
      end else if (busy) begin
        if (fall_ev && (bit_cnt != '0)) txsr <= {txsr[LONG_W-2:0], 1'b0};
        if (rise_ev) begin
          rxsr <= rx_next;
          if (last_bit) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            rx_word <= unpack_rx(rx_next, mode);
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_SOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fall_ev) |=> $stable(sout)); // R7
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R8
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_master,
  input  logic              cfg_lsb_first,
  input  logic              cfg_wide,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              start,
  input  logic [LONG_W-1:0] tx_word,
  input  logic              sck_in,
  input  logic              sin,
  output logic              sck_out,
  output logic              sout,
  output logic              busy,
  output logic              done,
  output logic [LONG_W-1:0] rx_word
);
  localparam int SYNC_STAGES = 2;

  sio_mode_t mode_q;
  logic      m_rise, m_fall;
  logic      s_sck, s_sck_d, s_sin;
  logic      s_rise, s_fall;
  logic      rise_ev, fall_ev, sin_bit;
  logic      mode_write;

  assign mode_write = cfg_we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{master: 1'b1, lsb_first: 1'b0, wide: 1'b0, div: '0};
    end else if (mode_write) begin
      mode_q <= '{master: cfg_master, lsb_first: cfg_lsb_first,
                  wide: cfg_wide, div: cfg_div};
    end
  end

  sio_clkgen u_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy && mode_q.master),
    .div     (mode_q.div),
    .sck     (sck_out),
    .rise_ev (m_rise),
    .fall_ev (m_fall)
  );

  sio_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sck (
    .clk (clk), .rst_n (rst_n), .d (sck_in), .q (s_sck)
  );
  sio_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sin (
    .clk (clk), .rst_n (rst_n), .d (sin), .q (s_sin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_sck_d <= 1'b1;
    else        s_sck_d <= s_sck;
  end

  assign s_rise  = s_sck && !s_sck_d;
  assign s_fall  = !s_sck && s_sck_d;
  assign rise_ev = mode_q.master ? m_rise : s_rise;
  assign fall_ev = mode_q.master ? m_fall : s_fall;
  assign sin_bit = mode_q.master ? sin    : s_sin;

  sio_shifter u_shifter (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tx_word (tx_word),
    .mode    (mode_q),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .sin_bit (sin_bit),
    .sout    (sout),
    .busy    (busy),
    .done    (done),
    .rx_word (rx_word)
  );

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q)); // R9
  AST_SLAVE_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q.master |-> sck_out); // R6
  AST_IDLE_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_out); // R2
endmodule

// File: tb/sio_port_tb.sv
module sio_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_master = 1'b1, cfg_lsb_first = 1'b0, cfg_wide = 1'b0;
  logic [3:0]  cfg_div = '0;
  logic        start = 1'b0;
  logic [15:0] tx_word = '0;
  logic        sck_in = 1'b1, sin = 1'b0;
  logic        sck_out, sout, busy, done;
  logic [15:0] rx_word;

  int checks = 0, failures = 0, cycles = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  sio_port u_dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // monitor: pops expected received words on each done pulse
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && done_prev) chk(0, "R8", "done longer than one cycle", 1, 0);
      if (done) begin
        if (exp_q.size() == 0) chk(0, "R8", "unexpected done", 1, 0);
        else begin
          automatic logic [15:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(rx_word == e, t, "rx_word", rx_word, e);
          chk(!busy, "R8", "busy low with done", busy, 0);
        end
      end
      done_prev = done;
    end
  end

  function automatic logic peer_bit(input logic [15:0] w, input int i,
                                    input bit lsb, input int n);
    return lsb ? w[i] : w[n-1-i];
  endfunction

  task automatic write_cfg(input bit m, input bit lsb, input bit wide, input logic [3:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_master = m; cfg_lsb_first = lsb; cfg_wide = wide; cfg_div = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run_master(input bit do_cfg, input bit lsb, input bit wide,
                            input logic [3:0] d, input logic [15:0] txw,
                            input logic [15:0] peer, input bit poke, input string tag);
    int n = wide ? 16 : 8;
    int falls = 0, rises = 0, cyc = 0, guard = 0, wait_n = 0;
    logic prev, cur, fall_sout;
    logic [15:0] got = '0;
    logic [15:0] mask = wide ? 16'hFFFF : 16'h00FF;
    if (do_cfg) write_cfg(1, lsb, wide, d);
    exp_q.push_back(peer & mask); tag_q.push_back(tag);
    @(negedge clk);
    start = 1; tx_word = txw;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R8", "busy after start", busy, 1);
    wait_n = 1;
    while (sck_out == 1 && guard < 200) begin @(negedge clk); wait_n++; guard++; end
    chk(wait_n == d + 2, "R2", "clocks to first fall", wait_n, d + 2);
    falls = 1; sin = peer_bit(peer, 0, lsb, n); fall_sout = sout; prev = 0;
    while (rises < n && guard < 2000) begin
      @(negedge clk); guard++; cyc++;
      cfg_we = 0; start = 0;
      cur = sck_out;
      if (prev && !cur) begin
        falls++; fall_sout = sout;
        if (falls <= n) sin = peer_bit(peer, falls - 1, lsb, n);
      end
      if (!prev && cur) begin
        rises++;
        if (lsb) got[rises-1] = sout; else got[n-rises] = sout;
        if (rises == 1) chk(cyc == d + 1, "R2", "half period", cyc, d + 1);
        if (rises == 2) chk(sout == fall_sout, "R7", "sout moved between fall and rise", sout, fall_sout);
        if (poke && rises == 1) begin
          cfg_we = 1; cfg_master = 0; cfg_lsb_first = ~lsb; cfg_wide = ~wide; cfg_div = ~d;
          start = 1; tx_word = ~txw;
        end
      end
      prev = cur;
    end
    cfg_we = 0; start = 0;
    repeat (2 * (d + 1) + 4) begin
      @(negedge clk);
      if (prev && !sck_out) falls++;
      prev = sck_out;
    end
    chk(falls == n, "R5", "serial clock cycles", falls, n);
    chk(got == (txw & mask), tag, "bits sent on sout", got, txw & mask);
    chk(busy == 0, "R8", "busy after transfer", busy, 0);
  endtask

  task automatic run_slave(input bit lsb, input bit wide, input logic [15:0] txw,
                           input logic [15:0] peer, input string tag);
    int n = wide ? 16 : 8;
    logic [15:0] got = '0;
    logic [15:0] mask = wide ? 16'hFFFF : 16'h00FF;
    bit sck_hi = 1;
    write_cfg(0, lsb, wide, 4'd0);
    exp_q.push_back(peer & mask); tag_q.push_back(tag);
    @(negedge clk);
    start = 1; tx_word = txw;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sck_in = 0; sin = peer_bit(peer, i, lsb, n);
      repeat (6) begin @(negedge clk); if (!sck_out) sck_hi = 0; end
      if (lsb) got[i] = sout; else got[n-1-i] = sout;
      sck_in = 1;
      repeat (6) begin @(negedge clk); if (!sck_out) sck_hi = 0; end
    end
    chk(sck_hi, "R6", "sck_out held high in slave", sck_hi, 1);
    chk(got == (txw & mask), tag, "slave bits sent", got, txw & mask);
    chk(busy == 0, "R8", "slave busy after transfer", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && sck_out == 1 && rx_word == 0, "R1", "reset outputs",
        {busy, done, sck_out}, 3'b001);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(busy == 0 && sck_out == 1 && rx_word == 0, "R1", "after reset release",
        {busy, sck_out}, 2'b01);
    run_master(1, 0, 1, 4'd1, 16'hA5C3, 16'h3C96, 0, "R3");
    run_master(1, 1, 1, 4'd3, 16'h1234, 16'h8001, 0, "R4");
    run_master(1, 0, 0, 4'd0, 16'h77A7, 16'hEE5B, 0, "R5");
    run_master(1, 1, 0, 4'd2, 16'h99C1, 16'h0036, 0, "R5");
    run_master(1, 0, 1, 4'd2, 16'h6E15, 16'hB2D4, 1, "R9");
    run_master(0, 0, 1, 4'd2, 16'h0F0F, 16'hF00F, 0, "R9");
    run_slave(0, 1, 16'hC3A5, 16'h5AF0, "R6");
    run_slave(1, 0, 16'h4D2B, 16'h00C9, "R6");
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "done pulses missing", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule